// File: doc/BRIEF.md
# Floppy Controller Host Register Front End

This block sits between a byte-wide host I/O bus and the command engine of a four-drive floppy disk controller. The host reaches it through a three-bit port offset with read and write strobes. Through these offsets the host can:

- read a status byte;
- read the kind of result the last command produced;
- read that result byte;
- build a 16-bit parameter-block address one byte at a time;
- issue a software reset.

Writing the high address byte launches the command engine. The engine then signals completion with a one-cycle strobe that carries a result type and a result byte. That completion sets an interrupt flip-flop, which the host acknowledges by reading the result-type port.

The block also watches four drive-ready inputs. Their registered copy appears in the status byte, and any change in them is remembered in a ready-change flag. When the result type says "ready status" and that flag is set, the result port shows a reordered ready byte instead of the error byte. The read data is combinational from the current offset and state. It is zero whenever no read strobe is present.

Top module: `fdc_host_regs`

## Requirements
- R1: A read of offset 0 returns the status byte. Bit 0 is ready of drive 0, bit 1 is drive 1, bit 5 is drive 2 and bit 6 is drive 3. Bit 2 is the interrupt flip-flop, bits 3 and 4 (controller present, double density) read one, and bit 7 reads zero.
- R2: A write to offset 1 loads the low byte of the parameter-block address. A write to offset 2 loads the high byte. `eng_addr` is {high, low}. A write to offset 2 while `eng_busy` is low raises `eng_start` for exactly the following cycle.
- R3: While `eng_busy` is high, writes to offsets 1 and 2 change neither address byte and produce no start pulse.
- R4: A read of offset 1 returns the stored result type in bits 1:0, with bits 7:2 zero. Code 00 means completion with error status and code 10 means ready status.
- R5: A read of offset 1 clears the interrupt flip-flop from the next cycle on. `irq` and status bit 2 both equal the flip-flop.
- R6: An `eng_done` strobe sets the interrupt flip-flop and stores `eng_rtype` and `eng_rbyte` from the next cycle on. A completion in the same cycle as an offset-1 read leaves the flip-flop set.
- R7: A read of offset 3 returns the stored error byte unless the result type is 10 and the ready-change flag is set.
- R8: When the result type is 10 and the ready-change flag is set, a read of offset 3 returns the ready byte. Its bit 7 is drive 1, bit 6 drive 0, bit 5 drive 3 and bit 4 drive 2, and bits 3:0 are zero.
- R9: The status ready bits follow `drive_ready` one cycle late. Any cycle in which `drive_ready` differs from the stored copy sets the ready-change flag.
- R10: Any write to offset 7 sets the result type to 00, clears the error byte and clears the ready-change flag. This takes priority over a completion in the same cycle. The interrupt flip-flop is left as it was.
- R11: Reads of offsets 2, 4, 5, 6 and 7 return zero, and the read data is zero with no read strobe. Writes to offsets 0, 3, 4, 5 and 6 change no state.
- R12: Synchronous reset clears the interrupt flip-flop, the result type, the error byte, the ready-change flag, the address latch and `eng_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Port offset from the base |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational |
| drive_ready | input | 4 | Ready level of drives 3..0 |
| eng_busy | input | 1 | Command engine is executing |
| eng_done | input | 1 | One-cycle completion strobe |
| eng_rtype | input | 2 | Result type given with completion |
| eng_rbyte | input | 8 | Result byte given with completion |
| eng_start | output | 1 | One-cycle command start pulse |
| eng_addr | output | 16 | Parameter-block address |
| irq | output | 1 | Interrupt request, equals the flip-flop |

## Verification
A wrong interrupt flip-flop shows on `irq` in the cycle after the completion or acknowledge that should have moved it, and also in status bit 2 on the next status read. A stale result type or error byte shows on the first read of offset 1 or 3 after the completion or software reset that should have replaced it. A lost ready-change flag stays hidden until a ready-type completion is followed by a read of offset 3, so the bench builds exactly that sequence. A reference model runs alongside the design and compares every output on every cycle, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/fdc_host_pkg.sv
package fdc_host_pkg;

    localparam int DATA_W     = 8;
    localparam int OFS_W      = 3;
    localparam int NUM_DRV    = 4;
    localparam int BLK_ADDR_W = 2 * DATA_W;
    localparam int RT_W       = 2;

    localparam logic [OFS_W-1:0] OFS_STATUS   = 3'd0;
    localparam logic [OFS_W-1:0] OFS_RTYPE    = 3'd1;
    localparam logic [OFS_W-1:0] OFS_ADDR_HI  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_RESULT   = 3'd3;
    localparam logic [OFS_W-1:0] OFS_SOFT_RST = 3'd7;

    typedef enum logic [RT_W-1:0] {
        RT_ERROR = 2'b00,
        RT_RSV1  = 2'b01,
        RT_READY = 2'b10,
        RT_RSV3  = 2'b11
    } rtype_e;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic wr_soft;
        logic rd_status;
        logic rd_rtype;
        logic rd_result;
    } host_req_t;

    typedef struct packed {
        rtype_e              rtype;
        logic [DATA_W-1:0]   err;
    } result_t;

    function automatic logic [DATA_W-1:0] pack_status(
        input logic [NUM_DRV-1:0] rdy,
        input logic               irq_ff
    );
        return {1'b0, rdy[3], rdy[2], 1'b1, 1'b1, irq_ff, rdy[1], rdy[0]};
    endfunction

    function automatic logic [DATA_W-1:0] pack_ready(
        input logic [NUM_DRV-1:0] rdy
    );
        return {rdy[1], rdy[0], rdy[3], rdy[2], 4'b0000};
    endfunction

endpackage

// File: rtl/fdc_host_decode.sv
module fdc_host_decode
    import fdc_host_pkg::*;
(
    input  logic [OFS_W-1:0] host_addr,
    input  logic             host_rd,
    input  logic             host_wr,
    output host_req_t        req
);

    always_comb begin
        req           = '0;
        req.wr_lo     = host_wr && (host_addr == OFS_RTYPE);
        req.wr_hi     = host_wr && (host_addr == OFS_ADDR_HI);
        req.wr_soft   = host_wr && (host_addr == OFS_SOFT_RST);
        req.rd_status = host_rd && (host_addr == OFS_STATUS);
        req.rd_rtype  = host_rd && (host_addr == OFS_RTYPE);
        req.rd_result = host_rd && (host_addr == OFS_RESULT);
    end

endmodule

// File: rtl/fdc_addr_latch.sv
module fdc_addr_latch
    import fdc_host_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  host_req_t             req,
    input  logic [DATA_W-1:0]     host_wdata,
    input  logic                  eng_busy,
    output logic                  eng_start,
    output logic [BLK_ADDR_W-1:0] eng_addr
);

    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic              start_q;
    logic              accept_lo;
    logic              accept_hi;

    assign accept_lo = req.wr_lo && !eng_busy;
    assign accept_hi = req.wr_hi && !eng_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            hi_q    <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= accept_hi;
            if (accept_lo) lo_q <= host_wdata;
            if (accept_hi) hi_q <= host_wdata;
        end
    end

    assign eng_start = start_q;
    assign eng_addr  = {hi_q, lo_q};

    a_r2_start_after_write: assert property (@(posedge clk) disable iff (rst)
        (req.wr_hi && !eng_busy) |=> eng_start);
    a_r3_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        (req.wr_hi && eng_busy) |=> !eng_start);
    a_r3_addr_hold_busy: assert property (@(posedge clk) disable iff (rst)
        eng_busy |=> $stable(eng_addr));

endmodule

// File: rtl/fdc_result_irq.sv
module fdc_result_irq
    import fdc_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_req_t         req,
    input  logic              eng_done,
    input  logic [RT_W-1:0]   eng_rtype,
    input  logic [DATA_W-1:0] eng_rbyte,
    output result_t           res,
    output logic              irq_ff
);

    result_t res_q;
    logic    irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q.rtype <= RT_ERROR;
            res_q.err   <= '0;
            irq_q       <= 1'b0;
        end else begin
            if (eng_done)          irq_q <= 1'b1;
            else if (req.rd_rtype) irq_q <= 1'b0;

            if (req.wr_soft) begin
                res_q.rtype <= RT_ERROR;
                res_q.err   <= '0;
            end else if (eng_done) begin
                res_q.rtype <= rtype_e'(eng_rtype);
                res_q.err   <= eng_rbyte;
            end
        end
    end

    assign res    = res_q;
    assign irq_ff = irq_q;

    a_r6_done_sets_irq: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> irq_ff);
    a_r5_ack_clears_irq: assert property (@(posedge clk) disable iff (rst)
        (req.rd_rtype && !eng_done) |=> !irq_ff);
    a_r6_capture_byte: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !req.wr_soft) |=> (res.err == $past(eng_rbyte)));
    a_r10_soft_clears_result: assert property (@(posedge clk) disable iff (rst)
        req.wr_soft |=> (res.rtype == RT_ERROR && res.err == '0));
    a_r10_soft_keeps_irq: assert property (@(posedge clk) disable iff (rst)
        (req.wr_soft && !eng_done && !req.rd_rtype) |=> (irq_ff == $past(irq_ff)));

endmodule

// File: rtl/fdc_ready_track.sv
module fdc_ready_track
    import fdc_host_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  host_req_t          req,
    input  logic [NUM_DRV-1:0] drive_ready,
    output logic [NUM_DRV-1:0] rdy,
    output logic               rdy_chg
);

    logic [NUM_DRV-1:0] rdy_q;
    logic [NUM_DRV-1:0] diff;
    logic               chg_q;

    generate
        for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
            assign diff[d] = drive_ready[d] ^ rdy_q[d];
        end
    endgenerate

    always_ff @(posedge clk) begin
        rdy_q <= drive_ready;
        if (rst || req.wr_soft) chg_q <= 1'b0;
        else if (|diff)         chg_q <= 1'b1;
    end

    assign rdy     = rdy_q;
    assign rdy_chg = chg_q;

    a_r9_change_sets_flag: assert property (@(posedge clk) disable iff (rst)
        ((drive_ready != rdy) && !req.wr_soft) |=> rdy_chg);
    a_r10_soft_clears_flag: assert property (@(posedge clk) disable iff (rst)
        req.wr_soft |=> !rdy_chg);

endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
    import fdc_host_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [OFS_W-1:0]      host_addr,
    input  logic                  host_rd,
    input  logic                  host_wr,
    input  logic [DATA_W-1:0]     host_wdata,
    output logic [DATA_W-1:0]     host_rdata,
    input  logic [NUM_DRV-1:0]    drive_ready,
    input  logic                  eng_busy,
    input  logic                  eng_done,
    input  logic [RT_W-1:0]       eng_rtype,
    input  logic [DATA_W-1:0]     eng_rbyte,
    output logic                  eng_start,
    output logic [BLK_ADDR_W-1:0] eng_addr,
    output logic                  irq
);

    host_req_t          req;
    result_t            res;
    logic               irq_ff;
    logic [NUM_DRV-1:0] rdy;
    logic               rdy_chg;

    fdc_host_decode u_decode (
        .host_addr (host_addr),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .req       (req)
    );

    fdc_addr_latch u_addr (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .host_wdata (host_wdata),
        .eng_busy   (eng_busy),
        .eng_start  (eng_start),
        .eng_addr   (eng_addr)
    );

    fdc_result_irq u_result (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .eng_done  (eng_done),
        .eng_rtype (eng_rtype),
        .eng_rbyte (eng_rbyte),
        .res       (res),
        .irq_ff    (irq_ff)
    );

    fdc_ready_track u_ready (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .drive_ready (drive_ready),
        .rdy         (rdy),
        .rdy_chg     (rdy_chg)
    );

    always_comb begin
        host_rdata = '0;
        unique case (1'b1)
            req.rd_status: host_rdata = pack_status(rdy, irq_ff);
            req.rd_rtype:  host_rdata = {{(DATA_W-RT_W){1'b0}}, res.rtype};
            req.rd_result: host_rdata = (res.rtype == RT_READY && rdy_chg)
                                        ? pack_ready(rdy) : res.err;
            default:       host_rdata = '0;
        endcase
    end

    assign irq = irq_ff;

    a_r1_status_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == OFS_STATUS) |->
            (host_rdata[7] == 1'b0 && host_rdata[4:3] == 2'b11 && host_rdata[2] == irq));
    a_r4_rtype_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == OFS_RTYPE) |-> (host_rdata[7:2] == '0));
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (!host_rd || host_addr == OFS_ADDR_HI || host_addr > OFS_RESULT) |-> (host_rdata == '0));

endmodule

// File: tb/fdc_host_regs_tb.sv
`timescale 1ns/100ps
module fdc_host_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [3:0]  drive_ready = 4'b0101;
    logic        eng_busy = 1'b0;
    logic        eng_done = 1'b0;
    logic [1:0]  eng_rtype = '0;
    logic [7:0]  eng_rbyte = '0;
    logic        eng_start;
    logic [15:0] eng_addr;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    bit model_live = 0;

    // reference model state
    logic       m_irq, m_chg, m_start;
    logic [1:0] m_rt;
    logic [7:0] m_err, m_lo, m_hi;
    logic [3:0] m_rdy;

    always #2.5 clk = ~clk;

    fdc_host_regs u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .drive_ready(drive_ready), .eng_busy(eng_busy), .eng_done(eng_done),
        .eng_rtype(eng_rtype), .eng_rbyte(eng_rbyte), .eng_start(eng_start),
        .eng_addr(eng_addr), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_irq = 0; m_chg = 0; m_start = 0; m_rt = 0; m_err = 0; m_lo = 0; m_hi = 0;
        end else begin
            m_start = host_wr && host_addr == 3'd2 && !eng_busy;
            if (host_wr && host_addr == 3'd1 && !eng_busy) m_lo = host_wdata;
            if (host_wr && host_addr == 3'd2 && !eng_busy) m_hi = host_wdata;
            if (eng_done) m_irq = 1;
            else if (host_rd && host_addr == 3'd1) m_irq = 0;
            if (host_wr && host_addr == 3'd7) begin
                m_rt = 0; m_err = 0; m_chg = 0;
            end else begin
                if (eng_done) begin m_rt = eng_rtype; m_err = eng_rbyte; end
                if (drive_ready != m_rdy) m_chg = 1;
            end
        end
        m_rdy = drive_ready;
        model_live = 1;
    end

    function automatic logic [7:0] exp_rdata();
        if (!host_rd) return 8'h00;
        case (host_addr)
            3'd0: return {1'b0, m_rdy[3], m_rdy[2], 2'b11, m_irq, m_rdy[1], m_rdy[0]};
            3'd1: return {6'b0, m_rt};
            3'd3: return (m_rt == 2'b10 && m_chg)
                         ? {m_rdy[1], m_rdy[0], m_rdy[3], m_rdy[2], 4'b0} : m_err;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag();
        if (!host_rd) return "R11 idle rdata";
        case (host_addr)
            3'd0: return "R1 status";
            3'd1: return "R4 rtype";
            3'd3: return (m_rt == 2'b10 && m_chg) ? "R8 ready byte" : "R7 error byte";
            default: return "R11 unmapped";
        endcase
    endfunction

    // per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        #1;
        if (model_live && !finished) begin
            chk(rd_tag(), {8'h0, host_rdata}, {8'h0, exp_rdata()});
            chk("R5 irq", {15'h0, irq}, {15'h0, m_irq});
            chk("R2 eng_start", {15'h0, eng_start}, {15'h0, m_start});
            chk("R2 eng_addr", eng_addr, {m_hi, m_lo});
        end
    end

    task automatic cyc(input logic rd, input logic wr, input logic [2:0] a, input logic [7:0] d,
                       input logic dn, input logic [1:0] rt, input logic [7:0] rb);
        @(negedge clk);
        host_rd = rd; host_wr = wr; host_addr = a; host_wdata = d;
        eng_done = dn; eng_rtype = rt; eng_rbyte = rb;
        #1;
    endtask

    task automatic idle();
        cyc(0, 0, 3'd0, 8'h00, 0, 2'b00, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        idle();
        // R12 reset state
        cyc(1, 0, 3'd0, 0, 0, 0, 0);
        chk("R12 status after reset", {8'h0, host_rdata}, 16'h0039);
        chk("R12 irq after reset", {15'h0, irq}, 16'h0);
        chk("R12 addr after reset", eng_addr, 16'h0000);
        cyc(1, 0, 3'd3, 0, 0, 0, 0);
        chk("R12 error byte after reset", {8'h0, host_rdata}, 16'h0000);
        // R2 address and start
        cyc(0, 1, 3'd1, 8'h34, 0, 0, 0);
        cyc(0, 1, 3'd2, 8'h12, 0, 0, 0);
        idle();
        chk("R2 start pulse", {15'h0, eng_start}, 16'h1);
        chk("R2 addr", eng_addr, 16'h1234);
        idle();
        chk("R2 pulse one cycle", {15'h0, eng_start}, 16'h0);
        // R3 busy blocks
        eng_busy = 1;
        cyc(0, 1, 3'd1, 8'hAA, 0, 0, 0);
        cyc(0, 1, 3'd2, 8'hBB, 0, 0, 0);
        idle();
        chk("R3 no start while busy", {15'h0, eng_start}, 16'h0);
        chk("R3 addr held while busy", eng_addr, 16'h1234);
        // R6 completion with error
        cyc(0, 0, 3'd0, 0, 1, 2'b00, 8'h28);
        eng_busy = 0;
        idle();
        chk("R6 irq set", {15'h0, irq}, 16'h1);
        cyc(1, 0, 3'd3, 0, 0, 0, 0);
        chk("R7 error byte", {8'h0, host_rdata}, 16'h0028);
        cyc(1, 0, 3'd0, 0, 0, 0, 0);
        chk("R1 status irq bit", {15'h0, host_rdata[2]}, 16'h1);
        // R5 acknowledge
        cyc(1, 0, 3'd1, 0, 0, 0, 0);
        chk("R4 rtype error", {8'h0, host_rdata}, 16'h0000);
        idle();
        chk("R5 irq cleared", {15'h0, irq}, 16'h0);
        // R9 / R8 ready change
        drive_ready = 4'b1010;
        idle();
        idle();
        cyc(1, 0, 3'd0, 0, 0, 0, 0);
        chk("R9 status tracks ready", {8'h0, host_rdata}, 16'h005A);
        cyc(0, 0, 3'd0, 0, 1, 2'b10, 8'h05);
        cyc(1, 0, 3'd3, 0, 0, 0, 0);
        chk("R8 ready byte", {8'h0, host_rdata}, 16'h00A0);
        cyc(1, 0, 3'd1, 0, 0, 0, 0);
        chk("R4 rtype ready", {8'h0, host_rdata}, 16'h0002);
        // R6 completion beats acknowledge
        cyc(1, 0, 3'd1, 0, 1, 2'b10, 8'h05);
        idle();
        chk("R6 done beats ack", {15'h0, irq}, 16'h1);
        // R10 soft reset
        cyc(0, 1, 3'd7, 8'h00, 0, 0, 0);
        cyc(1, 0, 3'd1, 0, 0, 0, 0);
        chk("R10 rtype cleared", {8'h0, host_rdata}, 16'h0000);
        chk("R10 irq kept", {15'h0, irq}, 16'h1);
        cyc(0, 0, 3'd0, 0, 1, 2'b10, 8'h11);
        cyc(1, 0, 3'd3, 0, 0, 0, 0);
        chk("R10 change flag cleared", {8'h0, host_rdata}, 16'h0011);
        cyc(0, 1, 3'd7, 8'h00, 1, 2'b10, 8'h77);
        cyc(1, 0, 3'd3, 0, 0, 0, 0);
        chk("R10 soft reset beats done", {8'h0, host_rdata}, 16'h0000);
        // R11 unmapped
        for (int a = 4; a < 8; a++) begin
            cyc(1, 0, 3'(a), 0, 0, 0, 0);
            chk("R11 unmapped read", {8'h0, host_rdata}, 16'h0000);
        end
        cyc(1, 0, 3'd2, 0, 0, 0, 0);
        chk("R11 offset 2 read", {8'h0, host_rdata}, 16'h0000);
        cyc(0, 1, 3'd0, 8'hFF, 0, 0, 0);
        cyc(0, 1, 3'd3, 8'hFF, 0, 0, 0);
        cyc(0, 1, 3'd5, 8'hFF, 0, 0, 0);
        cyc(1, 0, 3'd3, 0, 0, 0, 0);
        chk("R11 write ignored result", {8'h0, host_rdata}, 16'h0000);
        chk("R11 write ignored addr", eng_addr, 16'h1234);
        // mixed traffic, compared by the model every cycle
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            eng_busy = r[20];
            if (r[25:22] == 4'd0) drive_ready = r[29:26];
            cyc(r[0] & ~r[1], r[1] & ~r[0], r[4:2], r[12:5], r[13] & r[14], r[16:15], r[31:24]);
        end
        idle();
        idle();
        finished = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule